// File: doc/BRIEF.md
# Scatter-Gather Bus-Master DMA Engine

This block is the host side of a disk controller's bus-master DMA. Software writes a table base address and a command byte. The engine then reads a chain of eight-byte descriptors from host memory, and each descriptor names a buffer. Sector bytes move between the disk device and those buffers until either the table or the device runs out. The outcome is reported in a status byte and on an interrupt line.

Host memory is reached through a byte-wide request port that holds each request until it is acknowledged. The device side has two byte streams, one for each direction, with valid/ready handshakes. A shared `devLast` flag marks the device's final byte. The engine compares where the table ends with where the device ends. That comparison decides whether it stops silently, completes cleanly or waits for software with the transfer still active.

Top module: `sgDmaEngine`

## Requirements
- R1: After reset, the command byte (offset 0), the status byte (offset 2) and the four table-base bytes (offsets 4 to 7, least significant byte at 4) all read 0, and `irq` and `memReq` are low.
- R2: Writing the command byte with bit 0 set while the engine is idle starts the engine. It sets status bit 0 (ACTIVE) and reads the eight descriptor bytes at ascending addresses from the table base. Bytes 0 to 3 form the buffer address, least significant byte first.
- R3: Descriptor bytes 4 to 7 form a little-endian word. Bits 15:0 are the byte count, where 0 stands for 65536, and bit 31 marks the last descriptor. Descriptors are used in table order until the marked one is exhausted.
- R4: With command bit 3 set (device to memory), each byte the device offers is written to the next buffer address. The device byte is accepted in the same cycle the write is acknowledged.
- R5: With command bit 3 clear (memory to device), buffer bytes are read in address order and presented on the outgoing stream.
- R6: When the device's last byte is also the last byte of the last descriptor, status becomes 0x04 (bit 2 INTERRUPT set, ACTIVE clear).
- R7: When the last descriptor is exhausted before the device's last byte, status becomes 0x00, and no further device bytes are taken.
- R8: When the device's last byte arrives while descriptor bytes remain, status becomes 0x05. It stays there until software writes the command byte with bit 0 clear, after which status is 0x04.
- R9: Writing the command byte with bit 0 clear during a transfer ends it at once. ACTIVE clears, INTERRUPT is not set, and no further memory request or device handshake occurs.
- R10: Writing status with bit 2 set clears INTERRUPT, while a written 0 leaves it unchanged. `irq` equals the INTERRUPT bit.
- R11: While `busMasterEn` is low, `memReq` stays low. An engine started without permission reads ACTIVE until it is stopped.
- R12: A memory request that is not acknowledged keeps its address in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regAddr | input | 3 | Register byte offset |
| regWrEn | input | 1 | Register write strobe |
| regWrData | input | 8 | Register write byte |
| regRdData | output | 8 | Register read byte for `regAddr` |
| irq | output | 1 | Interrupt, follows status bit 2 |
| busMasterEn | input | 1 | Permission to access host memory |
| memReq | output | 1 | Memory request, held until acknowledged |
| memWe | output | 1 | 1 = write, 0 = read |
| memAddr | output | 32 | Memory byte address |
| memWdata | output | 8 | Memory write byte |
| memRdata | input | 8 | Memory read byte, valid with `memAck` |
| memAck | input | 1 | Memory acknowledge |
| devInValid | input | 1 | Device offers a byte (device to memory) |
| devInData | input | 8 | Device byte |
| devInReady | output | 1 | Engine takes the device byte |
| devOutValid | output | 1 | Engine offers a byte (memory to device) |
| devOutData | output | 8 | Byte to device |
| devOutReady | input | 1 | Device takes the byte |
| devLast | input | 1 | Current device handshake is the device's final byte |

## Verification
Single-descriptor transfers are run in both directions with three kinds of length pairing. In the first the table is shorter than the device transfer, in the second the lengths match, and in the third the table is longer. The three cases are told apart by the final status (0x00, 0x04 or 0x05) and by the number of bytes moved. A two-descriptor chain shows that the buffer address is switched at the boundary between descriptors. A zero count that outlasts a short device transfer shows that 0 is read as 65536. The memory acknowledge stalls on alternate cycles, which exercises held requests. Directed runs cover an abort in mid-transfer, the INTERRUPT write-one-to-clear and a start without bus-master permission.

// File: rtl/sgDmaPkg.sv
package sgDmaPkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH,
    ST_XFER,
    ST_PUSH,
    ST_HOLD
  } dmaState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic loadPtr;
    logic fetchStep;
    logic xferStep;
    logic latchByte;
    logic setActive;
    logic clrActive;
    logic setIntr;
    logic useBuf;
  } dmaStrobe_t;

  localparam int DESC_BYTES = 8;
  localparam int EOT_BIT    = 63;
  localparam int CNT_LSB    = 32;

endpackage

// File: rtl/sgDmaCtrl.sv
module sgDmaCtrl
  import sgDmaPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       startPulse,
  input  logic       stopPulse,
  input  logic       runDir,
  input  logic       fetchDone,
  input  logic       remLast,
  input  logic       descEot,
  input  logic       busMasterEn,
  input  logic       memAck,
  input  logic       devInValid,
  input  logic       devOutReady,
  input  logic       devLast,
  output dmaStrobe_t strobe,
  output logic       memReq,
  output logic       memWe,
  output logic       devInReady,
  output logic       devOutValid
);

  dmaState_e state, nextState;
  logic      byteDone;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    strobe      = '0;
    memReq      = 1'b0;
    memWe       = 1'b0;
    devInReady  = 1'b0;
    devOutValid = 1'b0;
    byteDone    = 1'b0;
    nextState   = state;

    unique case (state)
      ST_IDLE: begin
        if (startPulse) begin
          strobe.setActive = 1'b1;
          strobe.loadPtr   = 1'b1;
          nextState        = ST_FETCH;
        end
      end
      ST_FETCH: begin
        memReq = busMasterEn;
        if (memAck) begin
          strobe.fetchStep = 1'b1;
          if (fetchDone) nextState = ST_XFER;
        end
      end
      ST_XFER: begin
        strobe.useBuf = 1'b1;
        if (runDir) begin
          memReq     = busMasterEn && devInValid;
          memWe      = 1'b1;
          devInReady = memAck;
          byteDone   = memAck;
        end else begin
          memReq = busMasterEn;
          if (memAck) begin
            strobe.latchByte = 1'b1;
            nextState        = ST_PUSH;
          end
        end
      end
      ST_PUSH: begin
        strobe.useBuf = 1'b1;
        devOutValid   = 1'b1;
        byteDone      = devOutReady;
      end
      ST_HOLD: ;
      default: nextState = ST_IDLE;
    endcase

    // outcome of one moved byte
    if (byteDone) begin
      strobe.xferStep = 1'b1;
      if (devLast && remLast && descEot) begin
        strobe.setIntr   = 1'b1;
        strobe.clrActive = 1'b1;
        nextState        = ST_IDLE;
      end else if (devLast) begin
        strobe.setIntr = 1'b1;
        nextState      = ST_HOLD;
      end else if (remLast && descEot) begin
        strobe.clrActive = 1'b1;
        nextState        = ST_IDLE;
      end else if (remLast) begin
        nextState = ST_FETCH;
      end else begin
        nextState = ST_XFER;
      end
    end

    // software stop overrides everything
    if (stopPulse && state != ST_IDLE) begin
      strobe           = '0;
      strobe.clrActive = 1'b1;
      memReq           = 1'b0;
      devInReady       = 1'b0;
      devOutValid      = 1'b0;
      nextState        = ST_IDLE;
    end
  end

endmodule

// File: rtl/sgDmaDatapath.sv
module sgDmaDatapath
  import sgDmaPkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int CNT_W    = 16,
  parameter int REG_AW   = 3,
  parameter int BASE_OFF = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [REG_AW-1:0] regAddr,
  input  logic              regWrEn,
  input  logic [7:0]        regWrData,
  output logic [7:0]        regRdData,
  input  dmaStrobe_t        strobe,
  input  logic [7:0]        memRdata,
  input  logic [7:0]        devInData,
  output logic [ADDR_W-1:0] memAddr,
  output logic [7:0]        memWdata,
  output logic [7:0]        devOutData,
  output logic              startPulse,
  output logic              stopPulse,
  output logic              runDir,
  output logic              fetchDone,
  output logic              remLast,
  output logic              descEot,
  output logic              irq
);

  localparam int LANES  = ADDR_W / 8;
  localparam int REM_W  = CNT_W + 1;
  localparam int IDX_W  = $clog2(DESC_BYTES);
  localparam int DESC_W = DESC_BYTES * 8;

  logic [7:0]        tableByte [LANES];
  logic [ADDR_W-1:0] tableBase;
  logic              cmdStart, cmdDir, activeFlag, intrFlag;
  logic [ADDR_W-1:0] curPtr, bufAddr;
  logic [IDX_W-1:0]  byteIdx;
  logic [DESC_W-1:0] descShift, descNext;
  logic [REM_W-1:0]  remaining;
  logic [7:0]        outByte;
  logic              cmdWr, statWr;

  assign cmdWr      = regWrEn && regAddr == REG_AW'(0);
  assign statWr     = regWrEn && regAddr == REG_AW'(2);
  assign startPulse = cmdWr && regWrData[0] && !activeFlag;
  assign stopPulse  = cmdWr && !regWrData[0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmdStart <= 1'b0;
      cmdDir   <= 1'b0;
    end else if (cmdWr) begin
      cmdStart <= regWrData[0];
      cmdDir   <= regWrData[3];
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : gLane
    always_ff @(posedge clk) begin
      if (!rstN) tableByte[g] <= '0;
      else if (regWrEn && regAddr == REG_AW'(BASE_OFF + g)) tableByte[g] <= regWrData;
    end
    assign tableBase[8*g +: 8] = tableByte[g];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      activeFlag <= 1'b0;
      intrFlag   <= 1'b0;
      runDir     <= 1'b0;
    end else begin
      if (strobe.setActive) begin
        activeFlag <= 1'b1;
        runDir     <= regWrData[3];
      end else if (strobe.clrActive) begin
        activeFlag <= 1'b0;
      end
      if (strobe.setIntr)               intrFlag <= 1'b1;
      else if (statWr && regWrData[2])  intrFlag <= 1'b0;
    end
  end

  // descriptor assembly, little-endian byte order
  assign descNext  = {memRdata, descShift[DESC_W-1:8]};
  assign fetchDone = byteIdx == IDX_W'(DESC_BYTES - 1);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curPtr    <= '0;
      byteIdx   <= '0;
      descShift <= '0;
      bufAddr   <= '0;
      remaining <= '0;
      descEot   <= 1'b0;
      outByte   <= '0;
    end else begin
      if (strobe.loadPtr) begin
        curPtr  <= tableBase;
        byteIdx <= '0;
      end else if (strobe.fetchStep) begin
        curPtr    <= curPtr + 1'b1;
        byteIdx   <= byteIdx + 1'b1;
        descShift <= descNext;
        if (fetchDone) begin
          bufAddr <= descNext[ADDR_W-1:0];
          descEot <= descNext[EOT_BIT];
          if (descNext[CNT_LSB +: CNT_W] == '0) remaining <= {1'b1, {CNT_W{1'b0}}};
          else remaining <= {1'b0, descNext[CNT_LSB +: CNT_W]};
        end
      end
      if (strobe.xferStep) begin
        bufAddr   <= bufAddr + 1'b1;
        remaining <= remaining - 1'b1;
      end
      if (strobe.latchByte) outByte <= memRdata;
    end
  end

  assign remLast    = remaining == REM_W'(1);
  assign memAddr    = strobe.useBuf ? bufAddr : curPtr;
  assign memWdata   = devInData;
  assign devOutData = outByte;
  assign irq        = intrFlag;

  always_comb begin
    regRdData = '0;
    if (regAddr == REG_AW'(0))      regRdData = {4'b0, cmdDir, 2'b0, cmdStart};
    else if (regAddr == REG_AW'(2)) regRdData = {5'b0, intrFlag, 1'b0, activeFlag};
    else begin
      for (int i = 0; i < LANES; i++)
        if (regAddr == REG_AW'(BASE_OFF + i)) regRdData = tableByte[i];
    end
  end

endmodule

// File: rtl/sgDmaEngine.sv
module sgDmaEngine
  import sgDmaPkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [2:0]        regAddr,
  input  logic              regWrEn,
  input  logic [7:0]        regWrData,
  output logic [7:0]        regRdData,
  output logic              irq,
  input  logic              busMasterEn,
  output logic              memReq,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [7:0]        memWdata,
  input  logic [7:0]        memRdata,
  input  logic              memAck,
  input  logic              devInValid,
  input  logic [7:0]        devInData,
  output logic              devInReady,
  output logic              devOutValid,
  output logic [7:0]        devOutData,
  input  logic              devOutReady,
  input  logic              devLast
);

  dmaStrobe_t strobe;
  logic startPulse, stopPulse, runDir, fetchDone, remLast, descEot;

  sgDmaCtrl uCtrl (
    .clk(clk), .rstN(rstN),
    .startPulse(startPulse), .stopPulse(stopPulse), .runDir(runDir),
    .fetchDone(fetchDone), .remLast(remLast), .descEot(descEot),
    .busMasterEn(busMasterEn), .memAck(memAck),
    .devInValid(devInValid), .devOutReady(devOutReady), .devLast(devLast),
    .strobe(strobe), .memReq(memReq), .memWe(memWe),
    .devInReady(devInReady), .devOutValid(devOutValid)
  );

  sgDmaDatapath #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .REG_AW(3), .BASE_OFF(4)) uPath (
    .clk(clk), .rstN(rstN),
    .regAddr(regAddr), .regWrEn(regWrEn), .regWrData(regWrData), .regRdData(regRdData),
    .strobe(strobe), .memRdata(memRdata), .devInData(devInData),
    .memAddr(memAddr), .memWdata(memWdata), .devOutData(devOutData),
    .startPulse(startPulse), .stopPulse(stopPulse), .runDir(runDir),
    .fetchDone(fetchDone), .remLast(remLast), .descEot(descEot), .irq(irq)
  );

endmodule

// File: rtl/sgDmaChecker.sv
module sgDmaChecker #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic [2:0]        regAddr,
  input logic              regWrEn,
  input logic [7:0]        regWrData,
  input logic              irq,
  input logic              busMasterEn,
  input logic              memReq,
  input logic              memWe,
  input logic [ADDR_W-1:0] memAddr,
  input logic              memAck,
  input logic              devInValid,
  input logic              devInReady,
  input logic              devOutValid,
  input logic              devOutReady,
  input logic              devLast
);

  logic devHs, stopWr;
  assign devHs  = (devInValid && devInReady) || (devOutValid && devOutReady);
  assign stopWr = regWrEn && regAddr == 3'd0 && !regWrData[0];

  assert_mem_gated_R11: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> busMasterEn);

  assert_req_hold_R12: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memAck) |=> (!memReq || $stable(memAddr)));

  assert_dev_write_R4: assert property (@(posedge clk) disable iff (!rstN)
    devInReady |-> (memReq && memWe && memAck));

  assert_irq_source_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irq) |-> $past(devHs && devLast));

  assert_irq_clear_R10: assert property (@(posedge clk) disable iff (!rstN)
    $fell(irq) |-> $past(regWrEn && regAddr == 3'd2 && regWrData[2]));

  assert_stop_quiet_R9: assert property (@(posedge clk) disable iff (!rstN)
    stopWr |=> (!memReq && !devOutValid && !devInReady));

endmodule

bind sgDmaEngine sgDmaChecker #(.ADDR_W(ADDR_W)) chk (.*);

// File: tb/sgDmaEngine_test.sv
module sgDmaEngine_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [2:0]  regAddr = '0;
  logic        regWrEn = 1'b0;
  logic [7:0]  regWrData = '0;
  logic [7:0]  regRdData;
  logic        irq;
  logic        busMasterEn = 1'b1;
  logic        memReq, memWe, memAck;
  logic [31:0] memAddr;
  logic [7:0]  memWdata, memRdata;
  logic        devInValid, devInReady, devOutValid, devOutReady, devLast;
  logic [7:0]  devInData, devOutData;

  always #5 clk = ~clk;

  sgDmaEngine uut (.*);

  // memory and device models
  logic [7:0] mem [1024];
  logic [7:0] rxBuf [256];
  logic       ackPhase = 1'b0;
  logic       devRun = 1'b0, devDirIn = 1'b0, devClear = 1'b0;
  int         devLen = 0, devSent = 0, reqCount = 0;
  logic [7:0] patBase = '0;

  always @(negedge clk) ackPhase <= ~ackPhase;
  assign memAck      = memReq && ackPhase;
  assign memRdata    = mem[memAddr[9:0]];
  assign devInValid  = devRun && devDirIn && devSent < devLen;
  assign devInData   = patBase + 8'(devSent);
  assign devOutReady = devRun && !devDirIn && devSent < devLen;
  assign devLast     = devSent == devLen - 1;

  always @(posedge clk) begin
    if (devClear) begin
      devSent  <= 0;
      reqCount <= 0;
    end else begin
      if (memReq) reqCount <= reqCount + 1;
      if (memReq && memAck && memWe) mem[memAddr[9:0]] = memWdata;
      if (devInValid && devInReady) devSent <= devSent + 1;
      if (devOutValid && devOutReady) begin
        rxBuf[devSent[7:0]] = devOutData;
        devSent <= devSent + 1;
      end
    end
  end

  int checks = 0, errors = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wrReg(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rdReg(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    regAddr = a;
    #1 d = regRdData;
  endtask

  task automatic putDesc(input int slot, input logic [31:0] addr, input logic [15:0] cnt, input bit eot);
    logic [63:0] w;
    w = {eot, 15'b0, cnt, addr};
    for (int i = 0; i < 8; i++) mem[256 + 8*slot + i] = w[8*i +: 8];
  endtask

  task automatic devSetup(input bit dirIn, input int len, input logic [7:0] pat);
    @(negedge clk);
    devRun = 1'b0; devClear = 1'b1;
    @(negedge clk);
    devClear = 1'b0; devDirIn = dirIn; devLen = len; patBase = pat; devRun = 1'b1;
  endtask

  task automatic fillBuf();
    for (int i = 512; i < 1024; i++) mem[i] = 8'(i * 7 + 3) ^ 8'hEE;
  endtask

  task automatic startXfer(input bit dirIn);
    wrReg(3'd4, 8'h00); wrReg(3'd5, 8'h01); wrReg(3'd6, 8'h00); wrReg(3'd7, 8'h00);
    wrReg(3'd2, 8'h04);
    wrReg(3'd0, dirIn ? 8'h09 : 8'h01);
  endtask

  task automatic waitSettle(output logic [7:0] st);
    for (int i = 0; i < 3000; i++) begin
      rdReg(3'd2, st);
      if (!st[0] || st[2]) break;
    end
  endtask

  // {dirIn, count, devLen, expected status}
  localparam logic [40:0] VEC [7] = '{
    {1'b1, 16'd8,  16'd8,  8'h04},
    {1'b1, 16'd4,  16'd10, 8'h00},
    {1'b1, 16'd16, 16'd5,  8'h05},
    {1'b0, 16'd6,  16'd6,  8'h04},
    {1'b0, 16'd3,  16'd9,  8'h00},
    {1'b0, 16'd12, 16'd2,  8'h05},
    {1'b1, 16'd1,  16'd1,  8'h04}
  };

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual 0x0 expected 0x1");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] st, rd;
    int moved, bad, snap, snapReq;
    for (int i = 0; i < 1024; i++) mem[i] = '0;
    repeat (5) @(negedge clk);
    rstN = 1'b1;

    // R1 reset values
    bad = 0;
    for (int a = 0; a < 8; a++) begin
      rdReg(3'(a), rd);
      if (rd != 0) bad++;
    end
    check(bad == 0 && !irq && !memReq, "R1", bad, 0);

    // table of single-descriptor transfers
    for (int v = 0; v < 7; v++) begin
      logic        vDir;
      logic [15:0] vCnt, vLen;
      logic [7:0]  vExp;
      string       tag;
      {vDir, vCnt, vLen, vExp} = VEC[v];
      fillBuf();
      putDesc(0, 32'h200, vCnt, 1'b1);
      devSetup(vDir, int'(vLen), 8'(16 * v + 1));
      startXfer(vDir);
      waitSettle(st);
      tag = (vExp == 8'h04) ? "R6" : (vExp == 8'h00) ? "R7" : "R8";
      check(st == vExp, tag, st, vExp);
      check(irq == vExp[2], "R10", irq, vExp[2]);
      moved = (vCnt < vLen) ? int'(vCnt) : int'(vLen);
      repeat (4) @(negedge clk);
      check(devSent == moved, tag, devSent, moved);
      bad = 0;
      for (int i = 0; i < moved; i++) begin
        if (vDir && mem[512 + i] != 8'(16 * v + 1 + i)) bad++;
        if (!vDir && rxBuf[i] != (8'((512 + i) * 7 + 3) ^ 8'hEE)) bad++;
      end
      if (vDir && mem[512 + moved] != (8'((512 + moved) * 7 + 3) ^ 8'hEE)) bad++;
      check(bad == 0, vDir ? "R4 R2" : "R5 R2", bad, 0);
      if (vExp == 8'h05) begin
        wrReg(3'd0, 8'h00);
        rdReg(3'd2, st);
        check(st == 8'h04, "R8", st, 8'h04);
      end
    end

    // R10: write 0 keeps INTERRUPT, write 1 clears it
    fillBuf();
    putDesc(0, 32'h200, 16'd2, 1'b1);
    devSetup(1'b1, 2, 8'h30);
    startXfer(1'b1);
    waitSettle(st);
    wrReg(3'd2, 8'h00);
    rdReg(3'd2, st);
    check(st == 8'h04 && irq, "R10", st, 8'h04);
    wrReg(3'd2, 8'h04);
    rdReg(3'd2, st);
    check(st == 8'h00 && !irq, "R10", st, 8'h00);

    // R3 R12: two-descriptor chain under stalled acknowledges
    fillBuf();
    putDesc(0, 32'h200, 16'd3, 1'b0);
    putDesc(1, 32'h300, 16'd5, 1'b1);
    devSetup(1'b1, 8, 8'h40);
    startXfer(1'b1);
    waitSettle(st);
    check(st == 8'h04, "R3", st, 8'h04);
    bad = 0;
    for (int i = 0; i < 3; i++) if (mem[512 + i] != 8'(8'h40 + i)) bad++;
    for (int i = 0; i < 5; i++) if (mem[768 + i] != 8'(8'h43 + i)) bad++;
    if (mem[515] != (8'(515 * 7 + 3) ^ 8'hEE)) bad++;
    check(bad == 0, "R3 R12", bad, 0);

    // R3: count 0 means 65536, so a 4-byte device leaves the table long
    putDesc(0, 32'h200, 16'd0, 1'b1);
    devSetup(1'b1, 4, 8'h50);
    startXfer(1'b1);
    waitSettle(st);
    check(st == 8'h05, "R3", st, 8'h05);
    wrReg(3'd0, 8'h00);

    // R9: abort in mid transfer
    putDesc(0, 32'h200, 16'd200, 1'b1);
    devSetup(1'b1, 200, 8'h60);
    startXfer(1'b1);
    repeat (30) @(negedge clk);
    wrReg(3'd0, 8'h00);
    rdReg(3'd2, st);
    check(st == 8'h00 && !irq, "R9", st, 8'h00);
    snap = devSent; snapReq = reqCount;
    repeat (20) @(negedge clk);
    check(devSent == snap && reqCount == snapReq && snap < 200, "R9", devSent, snap);

    // R11: no bus-master permission
    busMasterEn = 1'b0;
    putDesc(0, 32'h200, 16'd4, 1'b1);
    devSetup(1'b1, 4, 8'h70);
    startXfer(1'b1);
    repeat (40) @(negedge clk);
    rdReg(3'd2, st);
    check(reqCount == 0 && devSent == 0, "R11", reqCount, 0);
    check(st == 8'h01, "R11", st, 8'h01);
    wrReg(3'd0, 8'h00);
    rdReg(3'd2, st);
    check(st == 8'h00, "R11", st, 8'h00);
    busMasterEn = 1'b1;

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule